// File: doc/BRIEF.md
# Configuration Lock Key Sequencer

This block guards the pin configuration of a port with a one-way lock. It watches bus accesses to a single lock register that is 17 bits wide. Bits 15:0 hold a pin mask, one bit per pin. Bit 16 is the key bit. Software arms the lock with a fixed access pattern: three writes, then two reads. Once the pattern completes with an unchanged mask, the masked pins are frozen. A frozen pin's mode, output type, speed, pull and alternate-function fields can no longer be written. The freeze lasts until the next reset.

The sequencer sees the lock register's select, the write and read strobes and the write data. It drives the per-pin freeze mask, a lock-active status bit and the value read back from the lock register. The per-pin configuration write enables pass through the block, and every frozen pin has its enable forced low. The configuration registers themselves live outside this block.

Top module: `cfg_lock_seq`

## Requirements
- R1: After reset, `key_o` is 0, `frz_mask_o` is 0, `rdata_o` is 0 and `cfg_we_o` equals `cfg_we_i`.
- R2: The lock becomes active after the following accesses to the lock register, in this order: a write with bit 16 = 1 and mask M, a write with bit 16 = 0 and mask M, a write with bit 16 = 1 and mask M, then two reads. After the clock edge of the second read, `key_o` is 1 and `frz_mask_o` equals M.
- R3: `rdata_o[15:0]` returns the mask from the last accepted write. During the first read after the three writes, `rdata_o[16]` is 0. During the second read it is 1, and it stays 1 while locked.
- R4: If the second or third write carries a mask different from the previous write, the sequence returns to idle. Completing the remaining steps then does not lock.
- R5: If any of the three writes carries the wrong key value, the sequence returns to idle. Only a write with key 1 starts a new sequence.
- R6: A write to the lock register after the third write, before or between the two reads, returns the sequence to idle without locking.
- R7: Two kinds of access leave the sequence unchanged: any access with `sel_i` = 0, and a read of the lock register before the third write.
- R8: Once locked, writes to the lock register are ignored. The mask readback, `frz_mask_o` and `key_o` stay unchanged until reset.
- R9: `cfg_we_o[i]` is `cfg_we_i[i]` with pin i forced low when `frz_mask_o[i]` is 1. The freeze starts in the cycle after the confirming read, so a configuration write in the same cycle as that read still passes.
- R10: A lock-register access with both `wr_i` and `rd_i` high counts only as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access targets the lock register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 17 | Write data: bit 16 key, bits 15:0 pin mask |
| cfg_we_i | input | 16 | Per-pin configuration write enables from the register file |
| cfg_we_o | output | 16 | Per-pin configuration write enables after freeze gating |
| frz_mask_o | output | 16 | Pins whose configuration is frozen |
| key_o | output | 1 | Lock active |
| rdata_o | output | 17 | Lock register readback: bit 16 key, bits 15:0 mask |

## Verification
Two functions can meet in one cycle.

The first case is the confirming read and the write gating. A configuration write is issued in the same cycle as the second read. The bench expects that write to pass, and expects the same pin to be blocked from the next cycle on.

The second case is a read and a write to the lock register in one cycle. This is provoked when the sequencer is waiting for its first read. One further plain read follows. Locking at that point would show that the access was taken as a read, so the bench judges it by `key_o` staying 0.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W1,
    ST_W2,
    ST_W3,
    ST_R1,
    ST_LOCK
  } lock_st_e;
endpackage

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
  import cfg_lock_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [NPINS:0]   wdata_i,
  output logic             locked_o,
  output logic             rkey_o,
  output logic [NPINS-1:0] mask_o
);

  lock_st_e         st_q, st_d;
  logic [NPINS-1:0] mask_q;
  logic             wr_hit, rd_hit, key, same;

  // write wins over read in a combined access
  assign wr_hit = sel_i & wr_i;
  assign rd_hit = sel_i & rd_i & ~wr_i;
  assign key    = wdata_i[NPINS];
  assign same   = (wdata_i[NPINS-1:0] == mask_q);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (wr_hit && key) st_d = ST_W1;
      ST_W1:   if (wr_hit) st_d = (!key && same) ? ST_W2 : ST_IDLE;
      ST_W2:   if (wr_hit) st_d = (key && same) ? ST_W3 : ST_IDLE;
      ST_W3: begin
        if (wr_hit)      st_d = ST_IDLE;
        else if (rd_hit) st_d = ST_R1;
      end
      ST_R1: begin
        if (wr_hit)      st_d = ST_IDLE;
        else if (rd_hit) st_d = ST_LOCK;
      end
      ST_LOCK: st_d = ST_LOCK;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
    end else begin
      st_q <= st_d;
      if (wr_hit && st_q != ST_LOCK) mask_q <= wdata_i[NPINS-1:0];
    end
  end

  assign locked_o = (st_q == ST_LOCK);
  assign rkey_o   = (st_q == ST_LOCK) || (st_q == ST_R1);
  assign mask_o   = mask_q;

  // R8
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOCK) |=> (st_q == ST_LOCK));
  // R8
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOCK) |=> $stable(mask_q));
  // R2
  lock_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_R1 && st_q != ST_LOCK) |=> (st_q != ST_LOCK));
  // R6
  late_write_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_W3 || st_q == ST_R1) && sel_i && wr_i) |=> (st_q == ST_IDLE));
  // R7
  unselected_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i) |=> $stable(st_q));

endmodule

// File: rtl/cfg_lock_gate.sv
module cfg_lock_gate #(
  parameter int NPINS = 16
) (
  input  logic [NPINS-1:0] we_i,
  input  logic [NPINS-1:0] frz_i,
  output logic [NPINS-1:0] we_o
);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign we_o[g] = we_i[g] & ~frz_i[g];
  end

endmodule

// File: rtl/cfg_lock_seq.sv
module cfg_lock_seq #(
  parameter int NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [NPINS:0]   wdata_i,
  input  logic [NPINS-1:0] cfg_we_i,
  output logic [NPINS-1:0] cfg_we_o,
  output logic [NPINS-1:0] frz_mask_o,
  output logic             key_o,
  output logic [NPINS:0]   rdata_o
);

  logic             locked, rkey;
  logic [NPINS-1:0] mask;

  cfg_lock_fsm #(.NPINS(NPINS)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .wdata_i  (wdata_i),
    .locked_o (locked),
    .rkey_o   (rkey),
    .mask_o   (mask)
  );

  assign frz_mask_o = locked ? mask : '0;
  assign key_o      = locked;
  assign rdata_o    = {rkey, mask};

  cfg_lock_gate #(.NPINS(NPINS)) u_gate (
    .we_i  (cfg_we_i),
    .frz_i (frz_mask_o),
    .we_o  (cfg_we_o)
  );

  // R1
  no_freeze_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_o |-> (frz_mask_o == '0));
  // R9
  frozen_we_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_o |-> ((cfg_we_o & rdata_o[NPINS-1:0]) == '0));

endmodule

// File: tb/cfg_lock_seq_bench.sv
module cfg_lock_seq_bench;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [N:0]   wdata = '0;
  logic [N-1:0] we_in = '0;
  logic [N-1:0] we_out, frz;
  logic         key;
  logic [N:0]   rdata;
  int           checks = 0, errors = 0;
  logic [N:0]   cap;
  logic [N-1:0] cap_we;

  always #2 clk = ~clk;

  cfg_lock_seq #(.NPINS(N)) u_cfg_lock_seq (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .cfg_we_i(we_in), .cfg_we_o(we_out),
    .frz_mask_o(frz), .key_o(key), .rdata_o(rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    sel = 0; wr = 0; rd = 0; wdata = '0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // one access; cap holds rdata/cfg_we_o seen during the access cycle
  task automatic acc(logic s, logic w, logic r, logic k, logic [N-1:0] m);
    @(negedge clk);
    sel = s; wr = w; rd = r; wdata = {k, m};
    #1;
    cap = rdata;
    cap_we = we_out;
    @(negedge clk);
    sel = 0; wr = 0; rd = 0;
  endtask

  task automatic lwr(logic k, logic [N-1:0] m);
    acc(1'b1, 1'b1, 1'b0, k, m);
  endtask

  task automatic lrd();
    acc(1'b1, 1'b0, 1'b1, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] m, m2;
    we_in = '1;
    do_reset();
    @(negedge clk);
    #1;
    chk("R1 key", 32'(key), 0);
    chk("R1 frz", 32'(frz), 0);
    chk("R1 rdata", 32'(rdata), 0);
    chk("R1 we pass", 32'(we_out), 32'(16'hFFFF));

    // main sequence over several masks
    for (int k = 0; k < 8; k++) begin
      m = 16'((k * 16'h3C5A) ^ (16'h1 << (2 * k)));
      do_reset();
      lwr(1'b1, m);
      lwr(1'b0, m);
      lwr(1'b1, m);
      lrd();
      chk("R3 first read key", 32'(cap), 32'({1'b0, m}));
      we_in = 16'hFFFF;
      lrd();
      chk("R3 second read key", 32'(cap), 32'({1'b1, m}));
      chk("R9 same-cycle write passes", 32'(cap_we), 32'(16'hFFFF));
      #1;
      chk("R2 key", 32'(key), 1);
      chk("R2 frz", 32'(frz), 32'(m));
      lwr(1'b1, ~m);
      lwr(1'b0, 16'h0);
      #1;
      chk("R8 rdata", 32'(rdata), 32'({1'b1, m}));
      chk("R8 frz", 32'(frz), 32'(m));
      for (int i = 0; i < N; i++) begin
        we_in = 16'(1) << i;
        #1;
        chk("R9 gate", 32'(we_out), m[i] ? 32'h0 : 32'(we_in));
      end
      do_reset();
      #1;
      chk("R1 reset clears lock", 32'(key), 0);
    end

    m = 16'h5A0F; m2 = 16'h5A1F;
    // R4 mask change at step two
    do_reset();
    lwr(1'b1, m); lwr(1'b0, m2); lwr(1'b1, m2); lrd(); lrd();
    #1; chk("R4 step2 mask change", 32'(key), 0);
    // R4 mask change at step three
    do_reset();
    lwr(1'b1, m); lwr(1'b0, m); lwr(1'b1, m2); lrd(); lrd();
    #1; chk("R4 step3 mask change", 32'(key), 0);
    chk("R3 mask readback", 32'(rdata), 32'({1'b0, m2}));
    // R5 wrong keys
    do_reset();
    lwr(1'b1, m); lwr(1'b1, m); lwr(1'b1, m); lrd(); lrd();
    #1; chk("R5 key1 at step two", 32'(key), 0);
    do_reset();
    lwr(1'b1, m); lwr(1'b0, m); lwr(1'b0, m); lrd(); lrd();
    #1; chk("R5 key0 at step three", 32'(key), 0);
    do_reset();
    lwr(1'b0, m); lwr(1'b0, m); lwr(1'b1, m); lrd(); lrd();
    #1; chk("R5 key0 at step one", 32'(key), 0);
    // R6 write in the read phase
    do_reset();
    lwr(1'b1, m); lwr(1'b0, m); lwr(1'b1, m); lwr(1'b1, m); lrd(); lrd();
    #1; chk("R6 write before reads", 32'(key), 0);
    do_reset();
    lwr(1'b1, m); lwr(1'b0, m); lwr(1'b1, m); lrd(); lwr(1'b1, m); lrd();
    #1; chk("R6 write between reads", 32'(key), 0);
    // R7 unselected traffic and early reads do not disturb
    do_reset();
    lwr(1'b1, m);
    acc(1'b0, 1'b1, 1'b0, 1'b0, 16'h1234);
    lrd();
    lwr(1'b0, m);
    acc(1'b0, 1'b0, 1'b1, 1'b0, '0);
    lrd();
    lwr(1'b1, m);
    acc(1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFF);
    lrd();
    acc(1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
    lrd();
    #1; chk("R7 interleaved accesses still lock", 32'(key), 1);
    chk("R7 mask unaffected", 32'(frz), 32'(m));
    // R10 combined read and write counts as write
    do_reset();
    lwr(1'b1, m); lwr(1'b0, m); lwr(1'b1, m);
    acc(1'b1, 1'b1, 1'b1, 1'b1, m);
    lrd();
    #1; chk("R10 combined access not a read", 32'(key), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule